// File: doc/BRIEF.md
# Outstanding Transaction and Bandwidth Throttle

This block sits on the read-address and write-address channels between an AXI master and its slave. It decides, cycle by cycle, whether an address request may pass. It is used to model a memory system that is busy with other traffic, so that the master's performance can be measured under controlled conditions. Data, response and address payload wires are routed around the block. The block only observes the R and B handshakes to learn when work completes.

A request passes only when four conditions hold. Pending reads are under their limit, pending writes are under theirs, and their sum is under a combined limit. A repeating on/off pulse pattern is in its on phase. The burst's words fit in what is left of the per-period word budget. Once a request has been presented downstream it stays presented until it is accepted, whatever the gating does.

Top module: `axi_addr_throttle`

## Requirements
- R1: A read counts as pending from its AR handshake. Reads are blocked while pending reads equal `rd_limit_i`. A limit of 0 selects the tracker capacity `PEND_MAX` (63 by default).
- R2: A write counts as pending from its AW handshake. Writes are blocked while pending writes equal `wr_limit_i`. A limit of 0 selects `PEND_MAX`.
- R3: Both address channels are blocked while pending reads plus pending writes reach `rw_limit_i`, where 0 means no combined limit. When a read is being presented in the same cycle, its slot is reserved first and the write sees the sum plus one.
- R4: A read stops being pending at an R handshake with the last flag set. R beats without the last flag free nothing. The freed slot is usable in the next cycle.
- R5: A write stops being pending at a B handshake. The freed slot is usable in the next cycle.
- R6: After reset the pattern starts with an on phase of `on_len_i` cycles, followed by an off phase of `off_len_i` cycles, and then repeats. Cycle j after reset release is open when j mod (on+off) < on. A phase of length 0 is skipped.
- R7: When both phase lengths are 0, the gate is always open and each cycle is its own budget period.
- R8: Each accepted burst is charged len+1 words, where len is the 8-bit burst length field. Reads and writes share the charge, with reads charged first in the same cycle. A burst that would push the period's total above `word_cap_i` is blocked, and one larger than the whole cap never passes. The total clears at the end of each period (the off phase's last cycle, or the on phase's last cycle when the off length is 0). A cap of 0 means unlimited.
- R9: Once a downstream valid is high without a ready, it stays high in the next cycle.
- R10: A blocked request has its downstream valid low and its upstream ready low. A passed request has its upstream ready equal to the downstream ready.
- R11: `capacity_o` always reads `PEND_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_limit_i | input | 6 | Pending read limit, 0 = capacity |
| wr_limit_i | input | 6 | Pending write limit, 0 = capacity |
| rw_limit_i | input | 6 | Combined pending limit, 0 = none |
| on_len_i | input | 16 | On-phase length in cycles |
| off_len_i | input | 16 | Off-phase length in cycles |
| word_cap_i | input | 16 | Words allowed per period, 0 = unlimited |
| capacity_o | output | 6 | Largest supported pending limit |
| s_arvalid_i | input | 1 | Read address valid from master |
| s_arlen_i | input | 8 | Read burst length minus one |
| s_arready_o | output | 1 | Read address ready to master |
| m_arvalid_o | output | 1 | Read address valid to slave |
| m_arready_i | input | 1 | Read address ready from slave |
| s_awvalid_i | input | 1 | Write address valid from master |
| s_awlen_i | input | 8 | Write burst length minus one |
| s_awready_o | output | 1 | Write address ready to master |
| m_awvalid_o | output | 1 | Write address valid to slave |
| m_awready_i | input | 1 | Write address ready from slave |
| r_valid_i | input | 1 | Observed read data valid |
| r_ready_i | input | 1 | Observed read data ready |
| r_last_i | input | 1 | Observed read data last flag |
| b_valid_i | input | 1 | Observed write response valid |
| b_ready_i | input | 1 | Observed write response ready |

## Verification
The pass/block decision is combinational from registered state. A request's fate therefore shows in the cycle it is presented, while the counts, the word total and the phase advance at the clock edge that ends that cycle. A completion, a period end or a phase change is visible one cycle later. The bench drives and samples every step one nanosecond after the falling edge. It counts a handshake in the step where downstream valid and ready are both high, and it indexes gate expectations by the step number since reset release, with step 0 being the cycle in which reset is released.

// File: rtl/axi_thr_pkg.sv
package axi_thr_pkg;
  typedef enum logic {PH_ON = 1'b0, PH_OFF = 1'b1} phase_e;
endpackage

// File: rtl/pend_tracker.sv
module pend_tracker #(
  parameter int PEND_MAX = 63,
  localparam int CNT_W = $clog2(PEND_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             retire_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({issue_i, retire_i})
        2'b10:   if (cnt_q != CNT_W'(PEND_MAX)) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pulse_gate.sv
module pulse_gate
  import axi_thr_pkg::*;
#(
  parameter int PH_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] on_len_i,
  input  logic [PH_W-1:0] off_len_i,
  output logic            open_o,
  output logic            period_end_o
);
  phase_e          ph_q;
  logic [PH_W-1:0] cnt_q;
  logic both_zero, on_done, off_done;

  always_comb begin
    both_zero    = (on_len_i == '0) && (off_len_i == '0);
    on_done      = (on_len_i == '0) || (cnt_q == PH_W'(on_len_i - 1'b1));
    off_done     = (off_len_i == '0) || (cnt_q == PH_W'(off_len_i - 1'b1));
    open_o       = both_zero || ((ph_q == PH_ON) && (on_len_i != '0));
    period_end_o = both_zero
                 || ((ph_q == PH_ON) && on_done && (off_len_i == '0))
                 || ((ph_q == PH_OFF) && off_done);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_ON;
      cnt_q <= '0;
    end else if (both_zero) begin
      ph_q  <= PH_ON;
      cnt_q <= '0;
    end else if (ph_q == PH_ON) begin
      if (on_done) begin
        cnt_q <= '0;
        ph_q  <= (off_len_i == '0) ? PH_ON : PH_OFF;
      end else cnt_q <= cnt_q + 1'b1;
    end else begin
      if (off_done) begin
        cnt_q <= '0;
        ph_q  <= PH_ON;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/word_budget.sv
module word_budget #(
  parameter int CAP_W = 16,
  parameter int WRD_W = 9,
  localparam int USE_W = CAP_W + 2,
  localparam int SUM_W = USE_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rd_fire_i,
  input  logic [WRD_W-1:0] rd_words_i,
  input  logic             wr_fire_i,
  input  logic [WRD_W-1:0] wr_words_i,
  output logic [USE_W-1:0] used_o
);
  logic [USE_W-1:0] used_q;
  logic [SUM_W-1:0] nxt;

  always_comb begin
    nxt = SUM_W'(used_q)
        + (rd_fire_i ? SUM_W'(rd_words_i) : '0)
        + (wr_fire_i ? SUM_W'(wr_words_i) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            used_q <= '0;
    else if (clear_i)       used_q <= '0;
    else if (nxt[SUM_W-1])  used_q <= '1;   // saturate
    else                    used_q <= nxt[USE_W-1:0];
  end

  assign used_o = used_q;
endmodule

// File: rtl/axi_addr_throttle.sv
module axi_addr_throttle #(
  parameter int PEND_MAX = 63,
  parameter int LIM_W    = 6,
  parameter int PH_W     = 16,
  parameter int CAP_W    = 16,
  parameter int LEN_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LIM_W-1:0] rd_limit_i,
  input  logic [LIM_W-1:0] wr_limit_i,
  input  logic [LIM_W-1:0] rw_limit_i,
  input  logic [PH_W-1:0]  on_len_i,
  input  logic [PH_W-1:0]  off_len_i,
  input  logic [CAP_W-1:0] word_cap_i,
  output logic [LIM_W-1:0] capacity_o,
  input  logic             s_arvalid_i,
  input  logic [LEN_W-1:0] s_arlen_i,
  output logic             s_arready_o,
  output logic             m_arvalid_o,
  input  logic             m_arready_i,
  input  logic             s_awvalid_i,
  input  logic [LEN_W-1:0] s_awlen_i,
  output logic             s_awready_o,
  output logic             m_awvalid_o,
  input  logic             m_awready_i,
  input  logic             r_valid_i,
  input  logic             r_ready_i,
  input  logic             r_last_i,
  input  logic             b_valid_i,
  input  logic             b_ready_i
);
  localparam int CNT_W = $clog2(PEND_MAX + 1);
  localparam int SUM_W = CNT_W + 1;
  localparam int WRD_W = LEN_W + 1;
  localparam int USE_W = CAP_W + 2;
  localparam int CMP_W = USE_W + 2;

  logic [CNT_W-1:0] rd_cnt, wr_cnt, rd_eff, wr_eff;
  logic [SUM_W-1:0] rw_sum, rw_eff;
  logic [USE_W-1:0] used;
  logic [WRD_W-1:0] rd_words, wr_words;
  logic gate_open, period_end;
  logic ar_hold_q, aw_hold_q;
  logic rd_ok, wr_ok, ar_fire, aw_fire, rd_done, wr_done;
  logic [CMP_W-1:0] rd_need, wr_need;

  pend_tracker #(.PEND_MAX(PEND_MAX)) u_rd_trk (
    .clk_i, .rst_ni, .issue_i(ar_fire), .retire_i(rd_done), .cnt_o(rd_cnt));
  pend_tracker #(.PEND_MAX(PEND_MAX)) u_wr_trk (
    .clk_i, .rst_ni, .issue_i(aw_fire), .retire_i(wr_done), .cnt_o(wr_cnt));

  pulse_gate #(.PH_W(PH_W)) u_gate (
    .clk_i, .rst_ni, .on_len_i, .off_len_i,
    .open_o(gate_open), .period_end_o(period_end));

  word_budget #(.CAP_W(CAP_W), .WRD_W(WRD_W)) u_budget (
    .clk_i, .rst_ni, .clear_i(period_end),
    .rd_fire_i(ar_fire), .rd_words_i(rd_words),
    .wr_fire_i(aw_fire), .wr_words_i(wr_words), .used_o(used));

  always_comb begin
    rd_eff   = (rd_limit_i == '0) ? CNT_W'(PEND_MAX) : CNT_W'(rd_limit_i);
    wr_eff   = (wr_limit_i == '0) ? CNT_W'(PEND_MAX) : CNT_W'(wr_limit_i);
    rw_eff   = (rw_limit_i == '0) ? SUM_W'(2 * PEND_MAX) : SUM_W'(rw_limit_i);
    rw_sum   = SUM_W'(rd_cnt) + SUM_W'(wr_cnt);
    rd_words = WRD_W'(s_arlen_i) + 1'b1;
    wr_words = WRD_W'(s_awlen_i) + 1'b1;

    rd_need = CMP_W'(used) + CMP_W'(rd_words);
    rd_ok   = gate_open && (rd_cnt < rd_eff) && (rw_sum < rw_eff)
           && ((word_cap_i == '0) || (rd_need <= CMP_W'(word_cap_i)));
    m_arvalid_o = s_arvalid_i && (rd_ok || ar_hold_q);
    s_arready_o = m_arvalid_o && m_arready_i;

    // a read presented this cycle reserves its slot and words first
    wr_need = CMP_W'(used) + CMP_W'(wr_words)
            + (m_arvalid_o ? CMP_W'(rd_words) : '0);
    wr_ok   = gate_open && (wr_cnt < wr_eff)
           && ((rw_sum + SUM_W'(m_arvalid_o)) < rw_eff)
           && ((word_cap_i == '0) || (wr_need <= CMP_W'(word_cap_i)));
    m_awvalid_o = s_awvalid_i && (wr_ok || aw_hold_q);
    s_awready_o = m_awvalid_o && m_awready_i;

    ar_fire = m_arvalid_o && m_arready_i;
    aw_fire = m_awvalid_o && m_awready_i;
    rd_done = r_valid_i && r_ready_i && r_last_i;
    wr_done = b_valid_i && b_ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_hold_q <= 1'b0;
      aw_hold_q <= 1'b0;
    end else begin
      ar_hold_q <= m_arvalid_o && !m_arready_i;
      aw_hold_q <= m_awvalid_o && !m_awready_i;
    end
  end

  assign capacity_o = LIM_W'(PEND_MAX);
endmodule

// File: rtl/axi_addr_throttle_chk.sv
module axi_addr_throttle_chk #(
  parameter int CNT_W = 6,
  parameter int LIM_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             m_arvalid_o,
  input logic             m_arready_i,
  input logic             m_awvalid_o,
  input logic             m_awready_i,
  input logic             s_arready_o,
  input logic             s_awready_o,
  input logic             r_valid_i,
  input logic             r_ready_i,
  input logic             r_last_i,
  input logic [LIM_W-1:0] rd_limit_i,
  input logic [CNT_W-1:0] rd_cnt,
  input logic             gate_open
);
  a_r9_ar_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_arvalid_o && !m_arready_i |=> m_arvalid_o);
  a_r9_aw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_awvalid_o && !m_awready_i |=> m_awvalid_o);
  a_r10_ar_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_arready_o |-> m_arvalid_o && m_arready_i);
  a_r10_aw_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_awready_o |-> m_awvalid_o && m_awready_i);
  a_r1_rd_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_limit_i != '0 |-> int'(rd_cnt) <= int'(rd_limit_i));
  a_r4_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_i && r_ready_i && r_last_i && !(m_arvalid_o && m_arready_i) && rd_cnt != '0
    |=> rd_cnt == CNT_W'($past(rd_cnt) - 1'b1));
  a_r6_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_arvalid_o) |-> gate_open);
endmodule

bind axi_addr_throttle axi_addr_throttle_chk #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .m_arvalid_o(m_arvalid_o), .m_arready_i(m_arready_i),
  .m_awvalid_o(m_awvalid_o), .m_awready_i(m_awready_i),
  .s_arready_o(s_arready_o), .s_awready_o(s_awready_o),
  .r_valid_i(r_valid_i), .r_ready_i(r_ready_i), .r_last_i(r_last_i),
  .rd_limit_i(rd_limit_i), .rd_cnt(rd_cnt), .gate_open(gate_open));

// File: tb/tb_axi_addr_throttle.sv
`timescale 1ns/1ps
module tb_axi_addr_throttle;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [5:0]  rd_limit_i = '0, wr_limit_i = '0, rw_limit_i = '0;
  logic [15:0] on_len_i = '0, off_len_i = '0, word_cap_i = '0;
  logic [5:0]  capacity_o;
  logic s_arvalid_i = 0, s_arready_o, m_arvalid_o, m_arready_i = 0;
  logic s_awvalid_i = 0, s_awready_o, m_awvalid_o, m_awready_i = 0;
  logic [7:0] s_arlen_i = '0, s_awlen_i = '0;
  logic r_valid_i = 0, r_ready_i = 0, r_last_i = 0, b_valid_i = 0, b_ready_i = 0;

  int n_chk = 0, n_err = 0;
  int nr, nw;

  always #2 clk_i = ~clk_i;

  axi_addr_throttle dut (.*);

  // {rd_limit, wr_limit, rw_limit, expected reads, expected writes} over 20 cycles
  localparam int VEC[5][5] = '{
    '{4, 3, 0, 4, 3},     // R1 R2
    '{0, 0, 5, 3, 2},     // R3
    '{2, 0, 6, 2, 4},     // R1 R3
    '{0, 0, 0, 20, 20},   // R7 open, no limits hit
    '{1, 1, 1, 1, 0}      // R3 read priority
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    s_arvalid_i = 0; s_awvalid_i = 0; m_arready_i = 0; m_awready_i = 0;
    s_arlen_i = '0; s_awlen_i = '0;
    r_valid_i = 0; r_ready_i = 0; r_last_i = 0; b_valid_i = 0; b_ready_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic count_hs();
    if (m_arvalid_o && m_arready_i) nr++;
    if (m_awvalid_o && m_awready_i) nw++;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    do_reset();
    #1;
    chk("R10 reset idle arvalid", m_arvalid_o, 0);
    chk("R10 reset idle awvalid", m_awvalid_o, 0);
    chk("R11 capacity", capacity_o, 63);

    // limit vectors, gate open (R7), no cap
    for (int v = 0; v < 5; v++) begin
      idle_inputs();
      rd_limit_i = 6'(VEC[v][0]); wr_limit_i = 6'(VEC[v][1]); rw_limit_i = 6'(VEC[v][2]);
      on_len_i = 0; off_len_i = 0; word_cap_i = 0;
      do_reset();
      nr = 0; nw = 0;
      for (int j = 0; j < 20; j++) begin
        if (j != 0) @(negedge clk_i);
        s_arvalid_i = 1; s_awvalid_i = 1; m_arready_i = 1; m_awready_i = 1;
        #1;
        count_hs();
      end
      chk($sformatf("R1 R3 vec%0d reads", v), nr, VEC[v][3]);
      chk($sformatf("R2 R3 vec%0d writes", v), nw, VEC[v][4]);
    end

    // R6 on=3 off=2
    idle_inputs();
    rd_limit_i = 0; wr_limit_i = 0; rw_limit_i = 0;
    on_len_i = 3; off_len_i = 2; word_cap_i = 0;
    do_reset();
    for (int j = 0; j < 15; j++) begin
      if (j != 0) @(negedge clk_i);
      s_arvalid_i = 1; m_arready_i = 1;
      #1;
      chk($sformatf("R6 gate step %0d", j), m_arvalid_o, ((j % 5) < 3) ? 1 : 0);
    end

    // R9/R10 held request across off phase, on=2 off=5
    idle_inputs();
    on_len_i = 2; off_len_i = 5;
    do_reset();
    for (int j = 0; j < 8; j++) begin
      if (j != 0) @(negedge clk_i);
      s_arvalid_i = 1;
      m_arready_i = (j == 3) ? 1'b1 : 1'b0;
      #1;
      if (j == 2) begin
        chk("R9 held in off phase", m_arvalid_o, 1);
        chk("R10 ready follows slave (low)", s_arready_o, 0);
      end
      if (j == 3) chk("R10 ready follows slave (high)", s_arready_o, 1);
      if (j == 4) begin
        chk("R10 new request blocked valid", m_arvalid_o, 0);
        chk("R10 new request blocked ready", s_arready_o, 0);
      end
      if (j == 7) chk("R6 next on phase", m_arvalid_o, 1);
    end

    // R4/R5 completions
    idle_inputs();
    on_len_i = 0; off_len_i = 0; rd_limit_i = 2; wr_limit_i = 1; rw_limit_i = 0;
    do_reset();
    for (int j = 0; j < 6; j++) begin
      if (j != 0) @(negedge clk_i);
      s_arvalid_i = 1; s_awvalid_i = 1; m_arready_i = 1; m_awready_i = 1;
      r_valid_i = (j == 2 || j == 3); r_ready_i = r_valid_i; r_last_i = (j == 3);
      b_valid_i = (j == 4); b_ready_i = b_valid_i;
      #1;
      if (j == 2) begin
        chk("R1 read full", m_arvalid_o, 0);
        chk("R2 write full", m_awvalid_o, 0);
      end
      if (j == 3) chk("R4 non-last beat frees nothing", m_arvalid_o, 0);
      if (j == 4) chk("R4 last beat frees slot", m_arvalid_o, 1);
      if (j == 5) begin
        chk("R5 B handshake frees slot", m_awvalid_o, 1);
        chk("R4 read full again", m_arvalid_o, 0);
      end
    end

    // R8 budget: cap 10, reads len 3 (4 words), period 20
    idle_inputs();
    rd_limit_i = 0; wr_limit_i = 0; rw_limit_i = 0;
    on_len_i = 20; off_len_i = 0; word_cap_i = 10;
    do_reset();
    nr = 0;
    for (int j = 0; j < 40; j++) begin
      if (j != 0) @(negedge clk_i);
      s_arvalid_i = 1; m_arready_i = 1; s_arlen_i = 8'd3;
      #1;
      count_hs();
      if (j == 19) chk("R8 first period reads", nr, 2);
    end
    chk("R8 second period reads", nr, 4);

    // R8 shared charge: read len 1 (2), write len 2 (3), cap 10
    idle_inputs();
    do_reset();
    nr = 0; nw = 0;
    for (int j = 0; j < 20; j++) begin
      if (j != 0) @(negedge clk_i);
      s_arvalid_i = 1; s_awvalid_i = 1; m_arready_i = 1; m_awready_i = 1;
      s_arlen_i = 8'd1; s_awlen_i = 8'd2;
      #1;
      count_hs();
    end
    chk("R8 shared reads", nr, 2);
    chk("R8 shared writes", nw, 2);

    // R8 oversize burst never passes
    idle_inputs();
    do_reset();
    nr = 0;
    for (int j = 0; j < 25; j++) begin
      if (j != 0) @(negedge clk_i);
      s_arvalid_i = 1; m_arready_i = 1; s_arlen_i = 8'd15;
      #1;
      count_hs();
    end
    chk("R8 oversize burst", nr, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule